// File: doc/BRIEF.md
# Processor Bus Address Decoder with Byte-Lane Steering

This block sits between a 16-bit processor and the targets that share its single address and data bus. Every cycle it takes the processor's address, access type (read or write) and access size (byte or word). It raises exactly one target select for the decoded region: byte-wide peripherals, word-wide peripherals, data SRAM, program SRAM, or the external memory port. It forwards the address and a write strobe to all targets. It also produces per-lane byte enables and write data with the byte placed in the correct lane.

On reads, the block picks the selected target's data and fits it to the access size. It then returns the result on a registered read bus one cycle after the address was presented. The lowest sixteen addresses belong to no target. An access there selects nothing, writes nothing, reads back zero, and produces a one-cycle error pulse that is aligned with the read data.

Top module: `bus_decoder`

## Requirements
- R1: An address in 0x0010–0x00FF with `bus_req` high raises `sel_p8` only, in the same cycle.
- R2: An address in 0x0100–0x01FF with `bus_req` high raises `sel_p16` only, in the same cycle.
- R3: An address in 0x0200–0x21FF with `bus_req` high raises `sel_dram` only, in the same cycle.
- R4: An address in 0xE000–0xFFFF, including the vector table at 0xFFE0–0xFFFF, raises `sel_pram` only, in the same cycle.
- R5: Any other address at or above 0x2200, that is 0x2200–0xDFFF, raises `sel_ext` only, in the same cycle.
- R6: An access to 0x0000–0x000F raises no select and no write strobe. It makes `bus_err` high for exactly the next cycle, with `bus_rdata` zero in that cycle.
- R7: At most one select is high in any cycle, and none is high while `bus_req` is low.
- R8: `bus_rdata` is registered. The cycle after a word read it equals the selected target's word. After reset, an idle cycle or a write, it is zero.
- R9: On a byte access, `tgt_be` has one bit set: bit 0 (lane 7:0) for an even address, bit 1 (lane 15:8) for an odd address. `tgt_wdata` carries `bus_wdata[7:0]` in that lane and zero in the other lane.
- R10: On a word access, `tgt_be` is 2'b11 and `tgt_wdata` equals `bus_wdata`.
- R11: A byte read from a 16-bit target returns the lane chosen by address bit 0, zero-extended into bits 7:0 of `bus_rdata`.
- R12: Any access to a byte-wide peripheral uses the low lane. A read returns `{8'h00, p8_rdata}`, and `p8_wdata` carries `bus_wdata[7:0]`.
- R13: `tgt_we` is high exactly when `bus_req` and `bus_we` are high and the address maps to a target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data from processor |
| bus_rdata | output | 16 | Registered read data to processor |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| sel_p8 | output | 1 | Byte-wide peripheral select |
| sel_p16 | output | 1 | Word-wide peripheral select |
| sel_dram | output | 1 | Data SRAM select |
| sel_pram | output | 1 | Program SRAM select |
| sel_ext | output | 1 | External memory port select |
| tgt_addr | output | 16 | Address forwarded to targets |
| tgt_we | output | 1 | Write strobe to targets |
| tgt_be | output | 2 | Byte-lane enables |
| tgt_wdata | output | 16 | Lane-steered write data |
| p8_wdata | output | 8 | Write byte for byte-wide peripherals |
| p8_rdata | input | 8 | Read byte from byte-wide peripherals |
| p16_rdata | input | 16 | Read word from word-wide peripherals |
| dram_rdata | input | 16 | Read word from data SRAM |
| pram_rdata | input | 16 | Read word from program SRAM |
| ext_rdata | input | 16 | Read word from external memory port |

## Verification
The bench probes the first and last address of every region: 0x000F against 0x0010, 0x00FF against 0x0100, 0x21FF against 0x2200, 0xDFFF against 0xE000, and the vector edge at 0xFFE0. An off-by-one comparator would show up there as the wrong select, or as a missing or spurious error pulse. Each probe is run at both address parities and with all four size and direction combinations. A design that steers the wrong lane would fail these, as would one that sign-extends or fails to zero-extend byte reads, or one that takes the high lane from a byte-wide peripheral on an odd address. Idle cycles and writes are placed between reads, so a read register that holds stale data instead of clearing shows up at once. Writes to the unmapped range confirm that no write strobe leaks out.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

   // decoded destination of one bus access
   typedef enum logic [2:0] {
      TGT_NONE = 3'd0,
      TGT_P8   = 3'd1,
      TGT_P16  = 3'd2,
      TGT_DRAM = 3'd3,
      TGT_PRAM = 3'd4,
      TGT_EXT  = 3'd5
   } tgt_e;

   // select vector bit positions (bit i belongs to target i+1)
   localparam int NUM_SEL  = 5;
   localparam int SEL_P8   = 0;
   localparam int SEL_P16  = 1;
   localparam int SEL_DRAM = 2;
   localparam int SEL_PRAM = 3;
   localparam int SEL_EXT  = 4;

endpackage

// File: rtl/bdec_region.sv
module bdec_region
   import bdec_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] P8_BASE   = 16'h0010,
   parameter logic [ADDR_W-1:0] P16_BASE  = 16'h0100,
   parameter logic [ADDR_W-1:0] DRAM_BASE = 16'h0200,
   parameter logic [ADDR_W-1:0] DRAM_LAST = 16'h21FF,
   parameter logic [ADDR_W-1:0] PRAM_BASE = 16'hE000
) (
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   output tgt_e              tgt,
   output logic [NUM_SEL-1:0] sel
);

   // ordered compare chain: regions are contiguous and ascending
   always_comb begin
      if (addr < P8_BASE)         tgt = TGT_NONE;
      else if (addr < P16_BASE)   tgt = TGT_P8;
      else if (addr < DRAM_BASE)  tgt = TGT_P16;
      else if (addr <= DRAM_LAST) tgt = TGT_DRAM;
      else if (addr >= PRAM_BASE) tgt = TGT_PRAM;
      else                        tgt = TGT_EXT;
   end

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
      assign sel[g] = req && (tgt == tgt_e'(3'(g + 1)));
   end

endmodule

// File: rtl/bdec_lanes.sv
module bdec_lanes #(
   parameter int DATA_W = 16,
   parameter int LANES  = DATA_W / 8,
   parameter int LSB_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              byte_acc,
   input  logic [LSB_W-1:0]  lane,
   input  logic [DATA_W-1:0] wdata_in,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] wdata_out
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic hit;
      assign hit   = !byte_acc || (lane == LSB_W'(g));
      assign be[g] = hit;
      assign wdata_out[g*8 +: 8] = !hit     ? 8'h00 :
                                   byte_acc ? wdata_in[7:0] :
                                              wdata_in[g*8 +: 8];
   end

endmodule

// File: rtl/bdec_rmux.sv
module bdec_rmux
   import bdec_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LANES  = DATA_W / 8,
   parameter int LSB_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic              byte_acc,
   input  logic [LSB_W-1:0]  lane,
   input  tgt_e              tgt,
   input  logic [7:0]        p8_rdata,
   input  logic [DATA_W-1:0] p16_rdata,
   input  logic [DATA_W-1:0] dram_rdata,
   input  logic [DATA_W-1:0] pram_rdata,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);

   logic [DATA_W-1:0] word_sel;
   logic [DATA_W-1:0] rd_next;
   logic [7:0]        lane_byte [LANES];
   logic [DATA_W-1:0] rd_q;
   logic              err_q;

   always_comb begin
      case (tgt)
         TGT_P8:   word_sel = {{(DATA_W-8){1'b0}}, p8_rdata};
         TGT_P16:  word_sel = p16_rdata;
         TGT_DRAM: word_sel = dram_rdata;
         TGT_PRAM: word_sel = pram_rdata;
         TGT_EXT:  word_sel = ext_rdata;
         default:  word_sel = '0;
      endcase
   end

   for (genvar g = 0; g < LANES; g++) begin : g_rlane
      assign lane_byte[g] = word_sel[g*8 +: 8];
   end

   // byte-wide peripherals always answer on the low lane
   always_comb begin
      if (!byte_acc || tgt == TGT_P8) rd_next = word_sel;
      else                            rd_next = {{(DATA_W-8){1'b0}}, lane_byte[lane]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         err_q <= 1'b0;
      end else begin
         rd_q  <= (req && !we) ? rd_next : '0;
         err_q <= req && (tgt == TGT_NONE);
      end
   end

   assign rdata = rd_q;
   assign err   = err_q;

   // R8: a word read from program SRAM comes back one cycle later
   p_pram_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we && !byte_acc && tgt == TGT_PRAM) |=> (rdata == $past(pram_rdata)));

   // R8: idle cycles leave zero on the read bus
   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (rdata == '0));

   // R6: an error cycle never carries read data
   p_err_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (rdata == '0));

   // R12: a word read from a byte peripheral keeps the high lane clear
   p_p8_high_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we && tgt == TGT_P8) |=> (rdata[DATA_W-1:8] == '0));

endmodule

// File: rtl/bus_decoder.sv
module bus_decoder
   import bdec_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 16,
   parameter logic [ADDR_W-1:0] P8_BASE   = 16'h0010,
   parameter logic [ADDR_W-1:0] P16_BASE  = 16'h0100,
   parameter logic [ADDR_W-1:0] DRAM_BASE = 16'h0200,
   parameter logic [ADDR_W-1:0] DRAM_LAST = 16'h21FF,
   parameter logic [ADDR_W-1:0] PRAM_BASE = 16'hE000,
   parameter logic [ADDR_W-1:0] VEC_BASE  = 16'hFFE0,
   localparam int               LANES     = DATA_W / 8,
   localparam int               LSB_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic              bus_byte,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   output logic              sel_p8,
   output logic              sel_p16,
   output logic              sel_dram,
   output logic              sel_pram,
   output logic              sel_ext,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic              tgt_we,
   output logic [LANES-1:0]  tgt_be,
   output logic [DATA_W-1:0] tgt_wdata,
   output logic [7:0]        p8_wdata,
   input  logic [7:0]        p8_rdata,
   input  logic [DATA_W-1:0] p16_rdata,
   input  logic [DATA_W-1:0] dram_rdata,
   input  logic [DATA_W-1:0] pram_rdata,
   input  logic [DATA_W-1:0] ext_rdata
);

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("bus_decoder: DATA_W must be a multiple of 8 and at least 16");
   end
   if (!(P8_BASE > 0 && P8_BASE < P16_BASE && P16_BASE < DRAM_BASE &&
         DRAM_BASE <= DRAM_LAST && DRAM_LAST < PRAM_BASE &&
         PRAM_BASE <= VEC_BASE)) begin : g_bad_map
      $error("bus_decoder: region bases must ascend without overlap");
   end

   tgt_e               tgt;
   logic [NUM_SEL-1:0] sel;
   logic [LSB_W-1:0]   lane;

   assign lane = bus_addr[LSB_W-1:0];

   bdec_region #(
      .ADDR_W   (ADDR_W),
      .P8_BASE  (P8_BASE),
      .P16_BASE (P16_BASE),
      .DRAM_BASE(DRAM_BASE),
      .DRAM_LAST(DRAM_LAST),
      .PRAM_BASE(PRAM_BASE)
   ) i_region (
      .req (bus_req),
      .addr(bus_addr),
      .tgt (tgt),
      .sel (sel)
   );

   bdec_lanes #(
      .DATA_W(DATA_W),
      .LANES (LANES),
      .LSB_W (LSB_W)
   ) i_lanes (
      .byte_acc (bus_byte),
      .lane     (lane),
      .wdata_in (bus_wdata),
      .be       (tgt_be),
      .wdata_out(tgt_wdata)
   );

   bdec_rmux #(
      .DATA_W(DATA_W),
      .LANES (LANES),
      .LSB_W (LSB_W)
   ) i_rmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (bus_req),
      .we        (bus_we),
      .byte_acc  (bus_byte),
      .lane      (lane),
      .tgt       (tgt),
      .p8_rdata  (p8_rdata),
      .p16_rdata (p16_rdata),
      .dram_rdata(dram_rdata),
      .pram_rdata(pram_rdata),
      .ext_rdata (ext_rdata),
      .rdata     (bus_rdata),
      .err       (bus_err)
   );

   assign sel_p8    = sel[SEL_P8];
   assign sel_p16   = sel[SEL_P16];
   assign sel_dram  = sel[SEL_DRAM];
   assign sel_pram  = sel[SEL_PRAM];
   assign sel_ext   = sel[SEL_EXT];
   assign tgt_addr  = bus_addr;
   assign tgt_we    = bus_req && bus_we && (tgt != TGT_NONE);
   assign p8_wdata  = bus_wdata[7:0];

   // R6: unmapped access yields an error pulse in the next cycle
   p_low_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_addr < P8_BASE) |=> bus_err);

   // R6: an error pulse always has an unmapped access behind it
   p_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> ($past(bus_req) && $past(bus_addr) < P8_BASE));

   // R7: no select and no strobe while idle
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |-> ({sel_ext, sel_pram, sel_dram, sel_p16, sel_p8} == '0 && !tgt_we));

   // R7: a mapped access raises exactly one select
   p_single_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_addr >= P8_BASE) |->
         ($countones({sel_ext, sel_pram, sel_dram, sel_p16, sel_p8}) == 1));

   // R4: the vector table belongs to program SRAM
   p_vec_pram_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_addr >= VEC_BASE) |-> sel_pram);

   // R5: the gap between the SRAMs goes off chip
   p_ext_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_addr > DRAM_LAST && bus_addr < PRAM_BASE) |-> sel_ext);

   // R9: byte accesses enable a single lane
   p_byte_be_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_byte) |-> $onehot(tgt_be));

   // R10: word accesses enable every lane
   p_word_be_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_byte) |-> (&tgt_be));

   // R13: a write strobe only goes to a selected target
   p_we_mapped_r13: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_we |-> (bus_we && $countones({sel_ext, sel_pram, sel_dram, sel_p16, sel_p8}) == 1));

endmodule

// File: tb/test_bus_decoder.sv
`timescale 1ns/1ps
module test_bus_decoder;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_req, bus_we, bus_byte;
   logic [15:0] bus_addr, bus_wdata, bus_rdata;
   logic        bus_err;
   logic        sel_p8, sel_p16, sel_dram, sel_pram, sel_ext;
   logic [15:0] tgt_addr, tgt_wdata;
   logic        tgt_we;
   logic [1:0]  tgt_be;
   logic [7:0]  p8_wdata, p8_rdata;
   logic [15:0] p16_rdata, dram_rdata, pram_rdata, ext_rdata;

   always #10 clk = ~clk;   // 50 MHz

   // simple target models: each answers with an address-dependent pattern
   assign p8_rdata   = tgt_addr[7:0] ^ 8'h5A;
   assign p16_rdata  = tgt_addr ^ 16'h9111;
   assign dram_rdata = tgt_addr ^ 16'hA2C2;
   assign pram_rdata = tgt_addr ^ 16'h3B83;
   assign ext_rdata  = tgt_addr ^ 16'hC4F4;

   bus_decoder i_bus_decoder (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .sel_p8(sel_p8),
      .sel_p16(sel_p16), .sel_dram(sel_dram), .sel_pram(sel_pram),
      .sel_ext(sel_ext), .tgt_addr(tgt_addr), .tgt_we(tgt_we),
      .tgt_be(tgt_be), .tgt_wdata(tgt_wdata), .p8_wdata(p8_wdata),
      .p8_rdata(p8_rdata), .p16_rdata(p16_rdata), .dram_rdata(dram_rdata),
      .pram_rdata(pram_rdata), .ext_rdata(ext_rdata)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done   = 0;
   logic [15:0] exp_rd  = '0;
   logic        exp_err = 1'b0;
   string       rd_tag  = "R8";

   task automatic chk(input string tag, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   // reference region: 0 none, 1 p8, 2 p16, 3 dram, 4 pram, 5 ext
   function automatic int ref_tgt(input int a);
      if (a < 'h10)    return 0;
      if (a < 'h100)   return 1;
      if (a < 'h200)   return 2;
      if (a <= 'h21FF) return 3;
      if (a >= 'hE000) return 4;
      return 5;
   endfunction

   function automatic logic [15:0] ref_word(input int t, input logic [15:0] a);
      case (t)
         1: return {8'h00, a[7:0] ^ 8'h5A};
         2: return a ^ 16'h9111;
         3: return a ^ 16'hA2C2;
         4: return a ^ 16'h3B83;
         5: return a ^ 16'hC4F4;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic string sel_tag(input int t);
      case (t)
         0: return "R6";
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         default: return "R5";
      endcase
   endfunction

   // one bus cycle: checks last cycle's registered outputs, drives, checks decode
   task automatic access(input logic req, input logic we, input logic byt,
                         input logic [15:0] a, input logic [15:0] wd);
      int          t;
      logic [4:0]  esel;
      logic [15:0] w;
      @(negedge clk);
      chk(rd_tag, "bus_rdata", {16'h0, bus_rdata}, {16'h0, exp_rd});
      chk("R6", "bus_err", {31'h0, bus_err}, {31'h0, exp_err});
      bus_req = req; bus_we = we; bus_byte = byt; bus_addr = a; bus_wdata = wd;
      #1;
      t    = ref_tgt(int'(a));
      esel = (req && t != 0) ? 5'(1 << (t - 1)) : 5'd0;
      chk(req ? sel_tag(t) : "R7", "selects",
          {27'h0, sel_ext, sel_pram, sel_dram, sel_p16, sel_p8}, {27'h0, esel});
      chk("R13", "tgt_we", {31'h0, tgt_we}, {31'h0, (req && we && t != 0)});
      if (req) begin
         if (byt) begin
            chk("R9", "tgt_be", {30'h0, tgt_be}, a[0] ? 32'h2 : 32'h1);
            chk("R9", "tgt_wdata", {16'h0, tgt_wdata},
                a[0] ? {16'h0, wd[7:0], 8'h00} : {16'h0, 8'h00, wd[7:0]});
         end else begin
            chk("R10", "tgt_be", {30'h0, tgt_be}, 32'h3);
            chk("R10", "tgt_wdata", {16'h0, tgt_wdata}, {16'h0, wd});
         end
         if (t == 1) chk("R12", "p8_wdata", {24'h0, p8_wdata}, {24'h0, wd[7:0]});
      end
      // expectation for the registered outputs of the next cycle
      w       = ref_word(t, a);
      exp_err = req && (t == 0);
      rd_tag  = "R8";
      if (!req || we || t == 0) begin
         exp_rd = 16'h0;
         if (req && t == 0) rd_tag = "R6";
      end else if (t == 1) begin
         exp_rd = w;
         rd_tag = "R12";
      end else if (byt) begin
         exp_rd = {8'h00, a[0] ? w[15:8] : w[7:0]};
         rd_tag = "R11";
      end else begin
         exp_rd = w;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R8 watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] edges [18] = '{16'h0000, 16'h000F, 16'h0010, 16'h0011,
                                  16'h00FF, 16'h0100, 16'h01FF, 16'h0200,
                                  16'h21FF, 16'h2200, 16'h2201, 16'hDFFF,
                                  16'hE000, 16'hE001, 16'hFFDF, 16'hFFE0,
                                  16'hFFE1, 16'hFFFF};
      rst_n = 1'b0; bus_req = 0; bus_we = 0; bus_byte = 0;
      bus_addr = '0; bus_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // reset state
      chk("R8", "reset bus_rdata", {16'h0, bus_rdata}, 32'h0);
      chk("R6", "reset bus_err", {31'h0, bus_err}, 32'h0);
      chk("R7", "reset selects",
          {27'h0, sel_ext, sel_pram, sel_dram, sel_p16, sel_p8}, 32'h0);

      // region edges, both parities, every size and direction
      foreach (edges[i]) begin
         access(1, 0, 0, edges[i], 16'h0000);
         access(1, 0, 1, edges[i], 16'h0000);
         access(1, 1, 1, edges[i], 16'hA5C3 ^ edges[i]);
         access(1, 1, 0, edges[i], 16'h6E19 ^ edges[i]);
         access(0, 0, 0, edges[i], 16'h0000);
         access(1, 0, 1, edges[i] ^ 16'h0001, 16'h0000);
      end

      // back-to-back unmapped accesses then a mapped read
      access(1, 0, 0, 16'h0004, 16'h0);
      access(1, 1, 0, 16'h0007, 16'hFFFF);
      access(1, 0, 0, 16'h0204, 16'h0);

      // mixed traffic, biased toward the low map
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] a;
         int          pick;
         pick = int'($urandom_range(0, 3));
         a = 16'($urandom);
         if (pick == 0) a = {7'h0, a[8:0]};
         access(($urandom_range(0, 7) != 0), 1'($urandom), 1'($urandom),
                a, 16'($urandom));
      end
      access(0, 0, 0, 16'h0, 16'h0);
      access(0, 0, 0, 16'h0, 16'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule